// File: doc/BRIEF.md
# Modulo-N Phase Accumulator Oscillator

This block is a numerically controlled oscillator. Its phase register holds an integer index that wraps at a modulus N, which can be changed while the block runs, rather than at a power of two. Every clock with enable high moves the phase forward by an integer step. The whole phase value addresses a sine table and a cosine table, and no bits are discarded on the way. The output frequency is fd = step × fs / N. When N is chosen so that N × fd / fs is an integer, no phase truncation occurs, so the output carries no truncation spurs. The sample clock is an input, and its frequency is picked outside the block.

A single table holds one full period of MAX_MOD signed samples and is computed at elaboration. For a runtime modulus N, the table stride is MAX_MOD / N, and the cosine is read a quarter period further along the same table. The controller is a three-state machine:
- **ST_IDLE** is entered at reset or whenever N is illegal.
- **ST_PREP** works out the stride by repeated subtraction. In the same cycles it reduces the held phase modulo the new N.
- **ST_RUN** produces samples.

The transitions are:
- IDLE→PREP when a legal N appears.
- PREP→PREP (reload) when N changes again.
- PREP→RUN when the stride and the phase are both settled.
- RUN→PREP when N changes.
- PREP→IDLE and RUN→IDLE when N becomes illegal.

Top module: `modn_nco`

## Requirements
- R1: While reset is high, and on the first sample after it, out_valid is 0 and phase_idx, sin_out and cos_out are all 0.
- R2: Two back-to-back samples under a fixed configuration have phases p and (p + step) mod N.
- R3: A sample with phase p carries sin_out = rnd(A·sin(2πp/N)) and cos_out = rnd(A·cos(2πp/N)). Here A = 2^(AMP_W−1) − 1, and rnd rounds half away from zero. N must divide MAX_MOD, and MAX_MOD must be a multiple of 4.
- R4: A clock edge in ST_RUN with en high produces exactly one sample, and out_valid rises one cycle after that edge. With en low, no sample appears and the phase holds.
- R5: cfg_bad is high when N < 2, N > MAX_MOD or step ≥ N. While it is high, no sample appears and the phase holds.
- R6: A new step applies from the next sample onward, with no jump or reset of the phase.
- R7: After N changes, the phase is kept and reduced modulo the new N. Samples resume after at most MAX_MOD/N + 2 cycles spent in ST_PREP.
- R8: With N = 200 and step = 6, the phase repeats after 100 samples (300 kHz from a 10 MHz sample clock).
- R9: With N = 2000 and step = 2, the phase repeats after 1000 samples (290 kHz from a 290 MHz sample clock).
- R10: Every valid sample has phase_idx < N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the phase and emit a sample |
| mod_n | input | W | Modulus N, where W = clog2(MAX_MOD+1) |
| step | input | W | Integer phase step, must be below N |
| cfg_bad | output | 1 | Current N or step is illegal |
| out_valid | output | 1 | Sample outputs hold a new sample |
| phase_idx | output | W | Phase index of the sample |
| sin_out | output | AMP_W | Signed sine sample |
| cos_out | output | AMP_W | Signed cosine sample |

## Verification
The hardest case to reach is a modulus hop in which the held phase is larger than the new N, because the reduction in ST_PREP must then do real work. The stimulus first drives the phase high under a large modulus with a large step. It then lowers N to a divisor that is well below that phase, and then lowers it further to a very small divisor. This forces ST_PREP both to take many stride iterations and to subtract the modulus several times. A scoreboard model reduces its own phase modulo each new N and expects the sample stream to continue from that point.

// File: rtl/modn_nco_pkg.sv
package modn_nco_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_RUN  = 2'd2
    } nco_state_e;
endpackage

// File: rtl/modn_nco_ctrl.sv
module modn_nco_ctrl
    import modn_nco_pkg::*;
#(
    parameter int MAX_MOD = 2000,
    parameter int W       = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] mod_n,
    input  logic [W-1:0] step,
    output logic [W-1:0] phase,
    output logic [W-1:0] stride,
    output logic         fire,
    output logic         cfg_bad
);
    localparam logic [W-1:0] MAX_N = W'(MAX_MOD);
    localparam logic [W-1:0] MIN_N = W'(2);

    nco_state_e state_q, state_d;

    logic [W-1:0] cur_n;
    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic         n_ok, step_ok, n_chg, prep_done, load;
    logic [W:0]   sum;
    logic [W-1:0] wrapped;

    always_comb begin
        n_ok      = (mod_n >= MIN_N) && (mod_n <= MAX_N);
        step_ok   = step < mod_n;
        cfg_bad   = !n_ok || !step_ok;
        n_chg     = mod_n != cur_n;
        prep_done = (rem_q < cur_n) && (phase < cur_n);
        sum       = {1'b0, phase} + {1'b0, step};
        wrapped   = (sum >= {1'b0, mod_n}) ? W'(sum - {1'b0, mod_n}) : sum[W-1:0];
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (n_ok) begin
                    state_d = ST_PREP;
                    load    = 1'b1;
                end
            end
            ST_PREP: begin
                if (!n_ok) begin
                    state_d = ST_IDLE;
                end else if (n_chg) begin
                    load = 1'b1;
                end else if (prep_done) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!n_ok) begin
                    state_d = ST_IDLE;
                end else if (n_chg) begin
                    state_d = ST_PREP;
                    load    = 1'b1;
                end else begin
                    fire = en && step_ok;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= '0;
            stride <= '0;
            cur_n  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
        end else if (load) begin
            cur_n <= mod_n;
            rem_q <= MAX_N;
            quo_q <= '0;
        end else if (state_q == ST_PREP && n_ok) begin
            if (rem_q >= cur_n) begin
                rem_q <= rem_q - cur_n;
                quo_q <= quo_q + W'(1);
            end
            if (phase >= cur_n) begin
                phase <= phase - cur_n;
            end
            if (prep_done) begin
                stride <= quo_q;
            end
        end else if (fire) begin
            phase <= wrapped;
        end
    end
endmodule

// File: rtl/modn_nco_rom.sv
module modn_nco_rom #(
    parameter int MAX_MOD = 2000,
    parameter int AMP_W   = 12,
    parameter int W       = 11
) (
    input  logic [W-1:0]              phase,
    input  logic [W-1:0]              stride,
    output logic signed [AMP_W-1:0]   sin_v,
    output logic signed [AMP_W-1:0]   cos_v
);
    localparam int              QTR    = MAX_MOD / 4;
    localparam real             AMP    = real'((1 << (AMP_W - 1)) - 1);
    localparam logic [2*W-1:0]  MAX_P  = (2*W)'(MAX_MOD);
    localparam logic [W:0]      MAX_S  = (W+1)'(MAX_MOD);
    localparam logic [W:0]      QTR_S  = (W+1)'(QTR);

    function automatic logic signed [AMP_W-1:0] code_at(input int k);
        real ang;
        real v;
        int  r;
        ang = 6.283185307179586 * real'(k) / real'(MAX_MOD);
        v   = AMP * $sin(ang);
        if (v >= 0.0) r = $rtoi(v + 0.5);
        else          r = -$rtoi(0.5 - v);
        return AMP_W'(r);
    endfunction

    logic signed [AMP_W-1:0] tab [MAX_MOD];

    for (genvar g = 0; g < MAX_MOD; g++) begin : g_tab
        localparam logic signed [AMP_W-1:0] CODE = code_at(g);
        assign tab[g] = CODE;
    end

    logic [2*W-1:0] prod;
    logic [W-1:0]   s_idx;
    logic [W:0]     c_sum;
    logic [W-1:0]   c_idx;

    always_comb begin
        prod  = {{W{1'b0}}, phase} * {{W{1'b0}}, stride};
        s_idx = (prod < MAX_P) ? prod[W-1:0] : '0;
        c_sum = {1'b0, s_idx} + QTR_S;
        c_idx = (c_sum >= MAX_S) ? W'(c_sum - MAX_S) : c_sum[W-1:0];
        sin_v = tab[s_idx];
        cos_v = tab[c_idx];
    end
endmodule

// File: rtl/modn_nco.sv
module modn_nco #(
    parameter int  MAX_MOD = 2000,
    parameter int  AMP_W   = 12,
    localparam int W       = $clog2(MAX_MOD + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [W-1:0]            mod_n,
    input  logic [W-1:0]            step,
    output logic                    cfg_bad,
    output logic                    out_valid,
    output logic [W-1:0]            phase_idx,
    output logic signed [AMP_W-1:0] sin_out,
    output logic signed [AMP_W-1:0] cos_out
);
    logic [W-1:0]            phase_cur;
    logic [W-1:0]            stride;
    logic                    fire;
    logic signed [AMP_W-1:0] sin_v, cos_v;

    modn_nco_ctrl #(.MAX_MOD(MAX_MOD), .W(W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .mod_n   (mod_n),
        .step    (step),
        .phase   (phase_cur),
        .stride  (stride),
        .fire    (fire),
        .cfg_bad (cfg_bad)
    );

    modn_nco_rom #(.MAX_MOD(MAX_MOD), .AMP_W(AMP_W), .W(W)) u_rom (
        .phase  (phase_cur),
        .stride (stride),
        .sin_v  (sin_v),
        .cos_v  (cos_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            phase_idx <= '0;
            sin_out   <= '0;
            cos_out   <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                phase_idx <= phase_cur;
                sin_out   <= sin_v;
                cos_out   <= cos_v;
            end
        end
    end
endmodule

// File: rtl/modn_nco_chk.sv
module modn_nco_chk #(
    parameter int  MAX_MOD = 2000,
    parameter int  AMP_W   = 12,
    localparam int W       = $clog2(MAX_MOD + 1)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    en,
    input logic [W-1:0]            mod_n,
    input logic [W-1:0]            step,
    input logic                    cfg_bad,
    input logic                    out_valid,
    input logic [W-1:0]            phase_idx,
    input logic signed [AMP_W-1:0] sin_out,
    input logic signed [AMP_W-1:0] cos_out
);
    localparam logic signed [AMP_W-1:0] PEAK = AMP_W'((1 << (AMP_W - 1)) - 1);

    logic         pv;
    logic [W-1:0] pphase, st_d1, st_d2, n_d1, n_d2;
    logic [W:0]   esum;
    logic [W-1:0] enext;

    always_ff @(posedge clk) begin
        if (rst) begin
            pv     <= 1'b0;
            pphase <= '0;
            st_d1  <= '0;
            st_d2  <= '0;
            n_d1   <= '0;
            n_d2   <= '0;
        end else begin
            pv     <= out_valid;
            pphase <= phase_idx;
            st_d1  <= step;
            st_d2  <= st_d1;
            n_d1   <= mod_n;
            n_d2   <= n_d1;
        end
    end

    always_comb begin
        esum  = {1'b0, pphase} + {1'b0, st_d2};
        enext = (esum >= {1'b0, n_d2}) ? W'(esum - {1'b0, n_d2}) : esum[W-1:0];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && phase_idx == '0));

    // R2
    phase_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pv) |-> phase_idx == enext);

    // R3
    zero_phase_amp_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && phase_idx == '0) |-> (sin_out == '0 && cos_out == PEAK));

    // R4
    enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !out_valid);

    // R5
    bad_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_bad |=> !out_valid);

    // R10
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> phase_idx < n_d1);
endmodule

bind modn_nco modn_nco_chk #(.MAX_MOD(MAX_MOD), .AMP_W(AMP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .mod_n     (mod_n),
    .step      (step),
    .cfg_bad   (cfg_bad),
    .out_valid (out_valid),
    .phase_idx (phase_idx),
    .sin_out   (sin_out),
    .cos_out   (cos_out)
);

// File: tb/modn_nco_bench.sv
`timescale 1ns/1ps
module modn_nco_bench;
    localparam int MAX_MOD = 2000;
    localparam int AMP_W   = 12;
    localparam int W       = $clog2(MAX_MOD + 1);
    localparam real AMPL   = 2047.0;
    localparam real TWO_PI = 6.283185307179586;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [W-1:0] mod_n = '0;
    logic [W-1:0] step  = '0;
    logic cfg_bad, out_valid;
    logic [W-1:0] phase_idx;
    logic signed [AMP_W-1:0] sin_out, cos_out;

    always #2 clk = ~clk;

    modn_nco #(.MAX_MOD(MAX_MOD), .AMP_W(AMP_W)) u_modn_nco (
        .clk(clk), .rst(rst), .en(en), .mod_n(mod_n), .step(step),
        .cfg_bad(cfg_bad), .out_valid(out_valid), .phase_idx(phase_idx),
        .sin_out(sin_out), .cos_out(cos_out)
    );

    typedef struct {
        int    ph;
        int    n;
        string req;
    } exp_t;

    exp_t  q[$];
    exp_t  cur;
    int    checks = 0;
    int    errors = 0;
    int    seen   = 0;
    int    mp     = 0;
    int    es, ec;
    bit    done   = 1'b0;

    function automatic int rnd(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(0.5 - v);
    endfunction

    function automatic int ref_sin(input int p, input int n);
        return rnd(AMPL * $sin(TWO_PI * real'(p) / real'(n)));
    endfunction

    function automatic int ref_cos(input int p, input int n);
        return rnd(AMPL * $cos(TWO_PI * real'(p) / real'(n)));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R4 unexpected sample actual phase %0d expected no sample", phase_idx);
            end else begin
                cur = q.pop_front();
                es  = ref_sin(cur.ph, cur.n);
                ec  = ref_cos(cur.ph, cur.n);
                if (int'(phase_idx) != cur.ph || int'(sin_out) != es || int'(cos_out) != ec) begin
                    errors++;
                    $display("FAIL %s actual phase %0d sin %0d cos %0d expected phase %0d sin %0d cos %0d",
                             cur.req, phase_idx, sin_out, cos_out, cur.ph, es, ec);
                end
            end
            seen++;
        end
    end

    // driver: push expected samples, then enable until they have all arrived
    task automatic run(input int n, input int s, input int cnt, input string req);
        int target;
        exp_t e;
        mod_n = W'(n);
        step  = W'(s);
        mp    = mp % n;
        for (int i = 0; i < cnt; i++) begin
            e.ph = mp; e.n = n; e.req = req;
            q.push_back(e);
            mp = (mp + s) % n;
        end
        target = seen + cnt;
        en = 1'b1;
        wait (seen >= target);
        en = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int s0;
        int p0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: state right after reset
        check(!out_valid, "R1 valid", int'(out_valid), 0);
        check(phase_idx == '0, "R1 phase", int'(phase_idx), 0);
        check(sin_out == '0 && cos_out == '0, "R1 samples", int'(sin_out), 0);
        // R5: N = 0 is illegal
        check(cfg_bad, "R5 zero modulus", int'(cfg_bad), 1);

        // R2 and R3: basic stream
        run(200, 6, 20, "R2");

        // R4: enable low holds phase and gives no samples
        s0 = seen;
        repeat (10) @(negedge clk);
        check(seen == s0, "R4 no sample with en low", seen - s0, 0);
        run(200, 6, 3, "R4");

        // R6: step change, phase continuous
        run(200, 13, 15, "R6");

        // R8: 100-sample period at N=200, step=6
        run(200, 6, 1, "R8");
        p0 = int'(phase_idx);
        run(200, 6, 100, "R8");
        check(int'(phase_idx) == p0, "R8 period", int'(phase_idx), p0);

        // R5: step not below N
        s0 = seen;
        step = W'(200);
        en = 1'b1;
        repeat (6) @(negedge clk);
        check(cfg_bad, "R5 step too large", int'(cfg_bad), 1);
        check(seen == s0, "R5 no sample", seen - s0, 0);
        en = 1'b0;
        mod_n = W'(1);
        @(negedge clk);
        check(cfg_bad, "R5 modulus below two", int'(cfg_bad), 1);
        run(200, 6, 4, "R5");

        // R7: modulus hops with phase reduction
        run(2000, 777, 5, "R7");
        run(200, 6, 10, "R7");
        run(8, 3, 12, "R7");
        run(400, 1, 5, "R3");

        // R9: 1000-sample period at N=2000, step=2
        run(2000, 2, 1, "R9");
        p0 = int'(phase_idx);
        run(2000, 2, 1000, "R9");
        check(int'(phase_idx) == p0, "R9 period", int'(phase_idx), p0);

        // R3: largest legal step
        run(2000, 1999, 4, "R3");

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R4 all samples delivered", q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule